// File: doc/BRIEF.md
# Hardware Cursor Sprite Overlay

This block lays a small two-bit-per-pixel cursor image over a video pixel stream. The display pipeline presents one pixel per clock, together with its raster column and row. The block decides whether that pixel lies inside the cursor window. If it does, the stored cursor code replaces the pixel with one of two cursor colours, leaves it as it is, or inverts it. The two cursor colours come from an external two-entry palette through input ports.

Software programs the cursor through a byte-wide register write port. The registers hold an 11-bit column and row start, a 6-bit skip on each axis that drops the first columns and rows of the image so the cursor can be clipped at the left and top edges, a show bit, a size bit and a pattern base address. Writing the load register makes the block copy the whole pattern from linear memory into an internal pattern RAM, one byte per cycle, through a simple read port with a fixed one-cycle return.

Top module: `curs_overlay`

## Requirements
- R1: Register addresses: 0 column start bits [7:0], 1 column start bits [10:8] taken from write data bits [2:0] (bits [7:3] ignored), 2 column skip from bits [5:0], 3 row start [7:0], 4 row start [10:8] from bits [2:0], 5 row skip from bits [5:0], 6 control, 7 pattern base [7:0], 8 pattern base [11:8] from bits [3:0], 9 load (any data).
- R2: Start and skip writes go to holding registers and only take effect on the clock edge where frame_start is high; until then the previous position stays in force.
- R3: Control bit 0 shows the cursor; while it is 0 every output pixel equals the input pixel.
- R4: Control bit 1 set gives a 64x64 sprite; clear gives a 32x32 sprite, using the first 256 pattern bytes with 8 bytes per row.
- R5: Pixel codes: 00 gives colour 0, 01 gives colour 1, 10 passes the video pixel, 11 outputs the bitwise inverse of the video pixel.
- R6: Sprite pixel (row r, column c) is held in pattern byte r*(side/4)+c/4, at bits [2p+1:2p] where p = c mod 4.
- R7: A pixel with column below the column start, row below the row start, or sprite column or row at or beyond the side passes the video unchanged.
- R8: The screen pixel at (start column, start row) shows sprite column = column skip and row = row skip; the window is shortened by the skip.
- R9: A load write fetches 1024 bytes from linear address base*1024+i for i = 0..1023 in increasing order, one request per cycle, the data returning one cycle after each request.
- R10: While a load is in progress every output pixel equals the input pixel.
- R11: The output pixel appears two clock edges after its inputs are sampled; during reset the output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| frame_start | input | 1 | Frame boundary pulse, commits held position |
| pix_x | input | 11 | Current raster column |
| pix_y | input | 11 | Current raster row |
| vid_in | input | PIX_W | Incoming video pixel |
| cur_col0 | input | PIX_W | Cursor colour 0 from palette |
| cur_col1 | input | PIX_W | Cursor colour 1 from palette |
| mem_rd_en | output | 1 | Pattern read request |
| mem_rd_addr | output | 22 | Pattern read byte address |
| mem_rd_data | input | 8 | Pattern read data, one cycle after request |
| pix_out | output | PIX_W | Final output pixel |

## Verification
The bench builds the block with its default geometry, an 11-bit raster, a 64-pixel maximum side and a 12-bit base, and narrows PIX_W to 8 so that inversion and colour choices read directly off one byte. The full 11-bit position lets the bench place the cursor at column 2040 and check the right edge of the raster. The 1024-byte pattern keeps two complete loads, at base 0 and at base 1, well inside the run. The bench memory returns a byte derived from address bits [11:10], so a wrong base shows up as different codes.

// File: rtl/curs_pkg.sv
// Shared definitions for the cursor overlay: register map and pixel codes.
package curs_pkg;

    // Register addresses of the byte-wide write port.
    typedef enum logic [3:0] {
        RA_XLO    = 4'd0,
        RA_XHI    = 4'd1,
        RA_XSKIP  = 4'd2,
        RA_YLO    = 4'd3,
        RA_YHI    = 4'd4,
        RA_YSKIP  = 4'd5,
        RA_CTRL   = 4'd6,
        RA_BASELO = 4'd7,
        RA_BASEHI = 4'd8,
        RA_LOAD   = 4'd9
    } reg_addr_e;

    // Two-bit cursor pixel codes.
    typedef enum logic [1:0] {
        PC_COLOR0 = 2'b00,
        PC_COLOR1 = 2'b01,
        PC_CLEAR  = 2'b10,
        PC_INVERT = 2'b11
    } pix_code_e;

    localparam int CTRL_SHOW_BIT = 0;
    localparam int CTRL_BIG_BIT  = 1;

endpackage

// File: rtl/curs_regs.sv
// Register file of the cursor overlay.
// Start and skip values land in holding registers and are copied to the
// active set on frame_start. Control and base apply at once. A write to the
// load address emits a one-cycle load_go pulse.
// Assumes POS_W > 8 and BASE_W > 8 (high parts live in a second register).
module curs_regs #(
    parameter int POS_W  = 11,
    parameter int PRE_W  = 6,
    parameter int BASE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [3:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              frame_start,
    output logic [POS_W-1:0]  act_xs,
    output logic [POS_W-1:0]  act_ys,
    output logic [PRE_W-1:0]  act_xskip,
    output logic [PRE_W-1:0]  act_yskip,
    output logic              show,
    output logic              big,
    output logic [BASE_W-1:0] base,
    output logic              load_go
);
    import curs_pkg::*;

    localparam int HI_W  = POS_W - 8;
    localparam int BHI_W = BASE_W - 8;

    logic [POS_W-1:0] hold_xs, hold_ys;
    logic [PRE_W-1:0] hold_xskip, hold_yskip;

    // Capture register writes into holding, control and base registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_xs    <= '0;
            hold_ys    <= '0;
            hold_xskip <= '0;
            hold_yskip <= '0;
            show       <= 1'b0;
            big        <= 1'b0;
            base       <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                RA_XLO:    hold_xs[7:0]        <= wr_data;
                RA_XHI:    hold_xs[POS_W-1:8]  <= wr_data[HI_W-1:0];
                RA_XSKIP:  hold_xskip          <= wr_data[PRE_W-1:0];
                RA_YLO:    hold_ys[7:0]        <= wr_data;
                RA_YHI:    hold_ys[POS_W-1:8]  <= wr_data[HI_W-1:0];
                RA_YSKIP:  hold_yskip          <= wr_data[PRE_W-1:0];
                RA_CTRL: begin
                    show <= wr_data[CTRL_SHOW_BIT];
                    big  <= wr_data[CTRL_BIG_BIT];
                end
                RA_BASELO: base[7:0]           <= wr_data;
                RA_BASEHI: base[BASE_W-1:8]    <= wr_data[BHI_W-1:0];
                default: ;
            endcase
        end
    end

    // Commit the held position at the frame boundary only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_xs    <= '0;
            act_ys    <= '0;
            act_xskip <= '0;
            act_yskip <= '0;
        end else if (frame_start) begin
            act_xs    <= hold_xs;
            act_ys    <= hold_ys;
            act_xskip <= hold_xskip;
            act_yskip <= hold_yskip;
        end
    end

    // One-cycle pulse for a write to the load address.
    always_ff @(posedge clk) begin
        if (!rst_n) load_go <= 1'b0;
        else        load_go <= wr_en && (wr_addr == RA_LOAD);
    end

endmodule

// File: rtl/curs_fetch.sv
// Pattern loader: on load_go copies 2**IDX_W bytes from linear memory,
// base*2**IDX_W upwards, into the pattern RAM. One request per cycle; the
// read port returns data exactly one cycle after each request. A go pulse
// that arrives while a load runs is ignored.
module curs_fetch #(
    parameter int IDX_W  = 10,
    parameter int BASE_W = 12,
    localparam int ADDR_W = BASE_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [BASE_W-1:0] base,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [7:0]        wr_data,
    output logic              loading
);
    logic              busy;
    logic [IDX_W-1:0]  cnt;
    logic [BASE_W-1:0] base_l;
    logic              pend;
    logic [IDX_W-1:0]  pend_idx;

    // Walk the byte counter while a load is active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            cnt    <= '0;
            base_l <= '0;
        end else if (go && !busy) begin
            busy   <= 1'b1;
            cnt    <= '0;
            base_l <= base;
        end else if (busy) begin
            cnt <= cnt + 1'b1;
            if (&cnt) busy <= 1'b0;
        end
    end

    // Remember which byte the returning data belongs to.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend     <= 1'b0;
            pend_idx <= '0;
        end else begin
            pend     <= busy;
            pend_idx <= cnt;
        end
    end

    assign rd_en   = busy;
    assign rd_addr = {base_l, cnt};
    assign wr_en   = pend;
    assign wr_idx  = pend_idx;
    assign wr_data = rd_data;
    assign loading = busy | pend;

endmodule

// File: rtl/curs_ram.sv
// Cursor pattern RAM: one write port, one registered read port.
// Contents are not reset; a load must precede display.
module curs_ram #(
    parameter int DEPTH = 1024,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data
);
    logic [7:0] mem [DEPTH];

    // Store loaded bytes.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
    end

    // Registered read for the display stage.
    always_ff @(posedge clk) begin
        rd_data <= mem[rd_idx];
    end

endmodule

// File: rtl/curs_locate.sv
// Window test and pattern addressing for one raster pixel.
// Sprite column = x - start + skip, sprite row likewise; the pixel is in the
// window when both are non-negative screen offsets and below the side length
// (DIM, or DIM/2 in small mode). Combinational.
module curs_locate #(
    parameter int POS_W = 11,
    parameter int PRE_W = 6,
    parameter int DIM   = 64,
    localparam int IDX_W = $clog2(DIM * DIM / 4)
) (
    input  logic [POS_W-1:0] x,
    input  logic [POS_W-1:0] y,
    input  logic [POS_W-1:0] xs,
    input  logic [POS_W-1:0] ys,
    input  logic [PRE_W-1:0] xskip,
    input  logic [PRE_W-1:0] yskip,
    input  logic             big,
    input  logic             enable,
    output logic             hit,
    output logic [IDX_W-1:0] idx,
    output logic [1:0]       sub
);
    localparam int CW = POS_W + 1;

    logic [CW-1:0] cx, cy, side, stride;

    // Compute sprite coordinates, window membership and byte index.
    always_comb begin
        side   = big ? CW'(DIM) : CW'(DIM / 2);
        stride = big ? CW'(DIM / 4) : CW'(DIM / 8);
        cx     = CW'(x) - CW'(xs) + CW'(xskip);
        cy     = CW'(y) - CW'(ys) + CW'(yskip);
        hit    = enable && (x >= xs) && (y >= ys) && (cx < side) && (cy < side);
        idx    = IDX_W'(cy * stride + (cx >> 2));
        sub    = cx[1:0];
    end

endmodule

// File: rtl/curs_mix.sv
// Per-pixel decode: picks the 2-bit code out of a pattern byte and maps it
// to colour 0, colour 1, the video pixel or its inverse. Outside the window
// the video pixel passes. Combinational.
module curs_mix #(
    parameter int PIX_W = 24
) (
    input  logic             hit,
    input  logic [7:0]       pat_byte,
    input  logic [1:0]       sub,
    input  logic [PIX_W-1:0] vid,
    input  logic [PIX_W-1:0] col0,
    input  logic [PIX_W-1:0] col1,
    output logic [PIX_W-1:0] pix
);
    import curs_pkg::*;

    pix_code_e code;

    // Select the code of pixel sub within the byte, lowest bits first.
    always_comb begin
        case (sub)
            2'd0:    code = pix_code_e'(pat_byte[1:0]);
            2'd1:    code = pix_code_e'(pat_byte[3:2]);
            2'd2:    code = pix_code_e'(pat_byte[5:4]);
            default: code = pix_code_e'(pat_byte[7:6]);
        endcase
    end

    // Map the code to the output pixel.
    always_comb begin
        if (!hit) begin
            pix = vid;
        end else begin
            case (code)
                PC_COLOR0: pix = col0;
                PC_COLOR1: pix = col1;
                PC_CLEAR:  pix = vid;
                default:   pix = ~vid;
            endcase
        end
    end

endmodule

// File: rtl/curs_overlay.sv
// Hardware cursor overlay top. Two-stage pixel pipeline: stage 1 locates
// the pixel and reads the pattern RAM, stage 2 decodes and registers the
// output. Assumes one valid pixel per clock and a pattern read port with a
// fixed one-cycle return.
module curs_overlay #(
    parameter int POS_W  = 11,
    parameter int PRE_W  = 6,
    parameter int DIM    = 64,
    parameter int BASE_W = 12,
    parameter int PIX_W  = 24,
    localparam int BYTES  = DIM * DIM / 4,
    localparam int IDX_W  = $clog2(BYTES),
    localparam int ADDR_W = BASE_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [3:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    input  logic              frame_start,
    input  logic [POS_W-1:0]  pix_x,
    input  logic [POS_W-1:0]  pix_y,
    input  logic [PIX_W-1:0]  vid_in,
    input  logic [PIX_W-1:0]  cur_col0,
    input  logic [PIX_W-1:0]  cur_col1,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [7:0]        mem_rd_data,
    output logic [PIX_W-1:0]  pix_out
);
    logic [POS_W-1:0]  act_xs, act_ys;
    logic [PRE_W-1:0]  act_xskip, act_yskip;
    logic              show_w, big_w, load_go;
    logic [BASE_W-1:0] base_w;
    logic              ram_we, loading;
    logic [IDX_W-1:0]  ram_widx, loc_idx;
    logic [7:0]        ram_wdata, ram_rdata;
    logic              loc_hit;
    logic [1:0]        loc_sub;
    logic              hit_q;
    logic [1:0]        sub_q;
    logic [PIX_W-1:0]  vid_q, mixed;

    curs_regs #(.POS_W(POS_W), .PRE_W(PRE_W), .BASE_W(BASE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_addr(reg_addr),
        .wr_data(reg_wdata), .frame_start(frame_start),
        .act_xs(act_xs), .act_ys(act_ys), .act_xskip(act_xskip),
        .act_yskip(act_yskip), .show(show_w), .big(big_w), .base(base_w),
        .load_go(load_go)
    );

    curs_fetch #(.IDX_W(IDX_W), .BASE_W(BASE_W)) u_fetch (
        .clk(clk), .rst_n(rst_n), .go(load_go), .base(base_w),
        .rd_en(mem_rd_en), .rd_addr(mem_rd_addr), .rd_data(mem_rd_data),
        .wr_en(ram_we), .wr_idx(ram_widx), .wr_data(ram_wdata),
        .loading(loading)
    );

    curs_locate #(.POS_W(POS_W), .PRE_W(PRE_W), .DIM(DIM)) u_loc (
        .x(pix_x), .y(pix_y), .xs(act_xs), .ys(act_ys),
        .xskip(act_xskip), .yskip(act_yskip), .big(big_w),
        .enable(show_w && !loading),
        .hit(loc_hit), .idx(loc_idx), .sub(loc_sub)
    );

    curs_ram #(.DEPTH(BYTES)) u_ram (
        .clk(clk), .wr_en(ram_we), .wr_idx(ram_widx), .wr_data(ram_wdata),
        .rd_idx(loc_idx), .rd_data(ram_rdata)
    );

    // Stage 1: carry window result, pixel slot and video alongside the RAM read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q <= 1'b0;
            sub_q <= '0;
            vid_q <= '0;
        end else begin
            hit_q <= loc_hit;
            sub_q <= loc_sub;
            vid_q <= vid_in;
        end
    end

    curs_mix #(.PIX_W(PIX_W)) u_mix (
        .hit(hit_q), .pat_byte(ram_rdata), .sub(sub_q), .vid(vid_q),
        .col0(cur_col0), .col1(cur_col1), .pix(mixed)
    );

    // Stage 2: register the final pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) pix_out <= '0;
        else        pix_out <= mixed;
    end

endmodule

// File: rtl/curs_overlay_chk.sv
// Property checker for the cursor overlay, bound to the top module.
// Observes ports and the signals passed between the register file, the
// loader and the pixel path.
module curs_overlay_chk #(
    parameter int POS_W  = 11,
    parameter int PIX_W  = 24,
    parameter int ADDR_W = 22
) (
    input logic              clk,
    input logic              rst_n,
    input logic              show,
    input logic              loading,
    input logic              frame_start,
    input logic [POS_W-1:0]  act_xs,
    input logic [POS_W-1:0]  pix_x,
    input logic [PIX_W-1:0]  vid_in,
    input logic [PIX_W-1:0]  pix_out,
    input logic              mem_rd_en,
    input logic [ADDR_W-1:0] mem_rd_addr
);
    logic [1:0] age;

    // Count clock edges since reset, saturating at 3.
    always_ff @(posedge clk) begin
        if (!rst_n)          age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    AST_HIDDEN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd2 && !$past(show, 2)) |-> pix_out == $past(vid_in, 2)); // R3

    AST_LOAD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd2 && $past(loading, 2)) |-> pix_out == $past(vid_in, 2)); // R10

    AST_LEFT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd2 && $past(pix_x, 2) < $past(act_xs, 2)) |-> pix_out == $past(vid_in, 2)); // R7

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (age != 2'd0 && mem_rd_en && $past(mem_rd_en)) |-> mem_rd_addr == ADDR_W'($past(mem_rd_addr) + 1'b1)); // R9

    AST_POS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (age != 2'd0 && !$past(frame_start)) |-> $stable(act_xs)); // R2

endmodule

bind curs_overlay curs_overlay_chk #(.POS_W(POS_W), .PIX_W(PIX_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .show(show_w), .loading(loading),
    .frame_start(frame_start), .act_xs(act_xs), .pix_x(pix_x),
    .vid_in(vid_in), .pix_out(pix_out), .mem_rd_en(mem_rd_en),
    .mem_rd_addr(mem_rd_addr)
);

// File: tb/sim_curs_overlay.sv
// Bench for the cursor overlay: vector table walk plus directed tests.
module sim_curs_overlay;
    localparam int CLK_PERIOD = 10;
    localparam int PIX_W = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic        frame_start = 1'b0;
    logic [10:0] pix_x = '0;
    logic [10:0] pix_y = '0;
    logic [7:0]  vid_in = '0;
    logic [7:0]  cur_col0 = 8'h11;
    logic [7:0]  cur_col1 = 8'h22;
    logic        mem_rd_en;
    logic [21:0] mem_rd_addr;
    logic [7:0]  mem_rd_data = '0;
    logic [7:0]  pix_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    int rd_cnt = 0;
    logic [21:0] first_addr = '0;
    logic [21:0] last_addr = '0;

    curs_overlay #(.PIX_W(PIX_W)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .frame_start(frame_start), .pix_x(pix_x),
        .pix_y(pix_y), .vid_in(vid_in), .cur_col0(cur_col0),
        .cur_col1(cur_col1), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_data(mem_rd_data), .pix_out(pix_out)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Linear memory model: byte = addr[7:0] ^ addr[11:10], one-cycle return.
    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rd_data <= mem_rd_addr[7:0] ^ {6'd0, mem_rd_addr[11:10]};
            if (rd_cnt == 0) first_addr <= mem_rd_addr;
            last_addr <= mem_rd_addr;
            rd_cnt <= rd_cnt + 1;
        end
    end

    typedef struct packed {
        logic [10:0] x;
        logic [10:0] y;
        logic [7:0]  vid;
        logic [7:0]  exp;
    } vec_t;

    // Cursor at (100,50), big, no skip, base 0: byte i holds i[7:0].
    localparam vec_t VEC [13] = '{
        '{11'd100, 11'd50,  8'h5A, 8'h11},
        '{11'd112, 11'd50,  8'h5A, 8'hA5},
        '{11'd104, 11'd50,  8'h5A, 8'h22},
        '{11'd108, 11'd50,  8'h5A, 8'h5A},
        '{11'd113, 11'd50,  8'h3C, 8'h11},
        '{11'd101, 11'd51,  8'h3C, 8'h11},
        '{11'd102, 11'd51,  8'h3C, 8'h22},
        '{11'd162, 11'd53,  8'h3C, 8'hC3},
        '{11'd163, 11'd113, 8'h0F, 8'hF0},
        '{11'd99,  11'd50,  8'h77, 8'h77},
        '{11'd164, 11'd50,  8'h77, 8'h77},
        '{11'd100, 11'd114, 8'h77, 8'h77},
        '{11'd100, 11'd49,  8'h77, 8'h77}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic frame();
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic drive_pix(input logic [10:0] x, input logic [10:0] y, input logic [7:0] v);
        pix_x = x; pix_y = y; vid_in = v;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R11 reset output", pix_out, 8'h00);
        rst_n = 1'b1;
        drive_pix(11'd100, 11'd50, 8'h33);
        check("R3 hidden after reset", pix_out, 8'h33);

        wr(4'd0, 8'd100); wr(4'd1, 8'hF8); wr(4'd3, 8'd50); wr(4'd4, 8'h00);
        wr(4'd6, 8'h03);
        frame();
        wr(4'd9, 8'h00);
        @(negedge clk);
        drive_pix(11'd100, 11'd50, 8'h44);
        check("R10 pass during load", pix_out, 8'h44);
        repeat (1100) @(negedge clk);
        check("R9 load count", rd_cnt, 1024);
        check("R9 first addr", first_addr, 22'd0);

        for (int i = 0; i < 13; i++) begin
            drive_pix(VEC[i].x, VEC[i].y, VEC[i].vid);
            check("R5/R6/R7/R1 table", pix_out, VEC[i].exp);
        end

        wr(4'd2, 8'hC4); wr(4'd5, 8'h41);
        drive_pix(11'd100, 11'd50, 8'h5A);
        check("R2 old position before frame", pix_out, 8'h11);
        frame();
        drive_pix(11'd100, 11'd50, 8'h5A);
        check("R8 skip origin", pix_out, 8'h22);
        drive_pix(11'd159, 11'd50, 8'h5A);
        check("R8 last column", pix_out, 8'h11);
        drive_pix(11'd160, 11'd50, 8'h5A);
        check("R8 shortened window", pix_out, 8'h5A);
        wr(4'd2, 8'h00); wr(4'd5, 8'h00);
        frame();

        wr(4'd6, 8'h01);
        drive_pix(11'd101, 11'd51, 8'h5A);
        check("R4 small row stride", pix_out, 8'h5A);
        drive_pix(11'd104, 11'd51, 8'h5A);
        check("R4 small byte 9", pix_out, 8'h22);
        drive_pix(11'd131, 11'd50, 8'h5A);
        check("R4 small last column", pix_out, 8'h11);
        drive_pix(11'd132, 11'd50, 8'h5A);
        check("R4 small edge", pix_out, 8'h5A);

        wr(4'd6, 8'h02);
        drive_pix(11'd100, 11'd50, 8'h5A);
        check("R3 hidden", pix_out, 8'h5A);
        wr(4'd6, 8'h03);

        wr(4'd0, 8'hF8); wr(4'd1, 8'hFF);
        frame();
        drive_pix(11'd2047, 11'd50, 8'h5A);
        check("R1 high bits masked right edge", pix_out, 8'h11);
        drive_pix(11'd2039, 11'd50, 8'h5A);
        check("R7 left of start", pix_out, 8'h5A);
        wr(4'd0, 8'd100); wr(4'd1, 8'h00);
        frame();

        rd_cnt = 0;
        wr(4'd7, 8'h01); wr(4'd8, 8'hF0);
        wr(4'd9, 8'h5A);
        repeat (1100) @(negedge clk);
        check("R9 reload count", rd_cnt, 1024);
        check("R9 base first addr", first_addr, 22'd1024);
        check("R9 base last addr", last_addr, 22'd2047);
        drive_pix(11'd100, 11'd50, 8'h5A);
        check("R9 base data", pix_out, 8'h22);
        drive_pix(11'd112, 11'd50, 8'h5A);
        check("R9 base data clear", pix_out, 8'h5A);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule